// File: doc/BRIEF.md
# DMA Status and Interrupt Register Bank

This block is the register slice that a DMA engine exposes to software for reporting progress and raising an interrupt. A read-only engine status word shows two live levels from the datapath: whether a transfer is running and whether the bus has reported an error. An interrupt status word captures one-cycle done and error events from the datapath. Software clears a captured bit by writing a one to it.

An interrupt enable word selects which captured bits drive the single interrupt line. The enable word never stops a bit from being captured or read back.

Software reaches all three words through a simple register port. The port has separate read and write strobes, a byte offset, and read data that is registered with one cycle of latency. The reset input is asynchronous and active low. Inside the block it is released in step with the clock.

Top module: `dma_stat_irq_regs`

## Requirements
- R1: A read at offset 0x14 returns the live busy level in bit 0 and the live bus-error level in bit 1. Bits 31 to 2 read 0.
- R2: A write to offset 0x14 has no effect. Later reads of 0x14 still show only the live levels, and the other words are unchanged.
- R3: A one-cycle pulse on `evt_done` sets interrupt status bit 31, and a pulse on `evt_err` sets bit 30. Each bit is set in the cycle after the pulse, whatever the enable word holds. Bits 29 to 0 of this word (offset 0x2C) read 0.
- R4: A write to offset 0x2C inverts each of bits 31 and 30 whose write-data bit is 1. It leaves unchanged each bit whose write-data bit is 0.
- R5: If an event and a write to 0x2C reach the same status bit in the same cycle, the bit ends up set.
- R6: The enable word at offset 0x30 is read/write in bits 31 (done) and 30 (error). Its other bits read 0.
- R7: `irq` is a registered level. It is high in the cycle after any of bits 31 or 30 is set in both the status word and the enable word.
- R8: A read of any other offset returns 0. A write to any other offset changes nothing.
- R9: `reg_rdata` shows the addressed word in the cycle after `reg_rd`. The value is taken as it was before any write in the same cycle.
- R10: While reset is held, and on release, the status word, the enable word, `reg_rdata` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid one cycle after the read strobe |
| eng_busy | input | 1 | Transfer-in-progress level from the engine |
| eng_bus_err | input | 1 | Bus-error level from the engine |
| evt_done | input | 1 | One-cycle transfer-done event |
| evt_err | input | 1 | One-cycle error event |
| irq | output | 1 | Interrupt request level |

## Verification
The bench drives a done or error event in the same cycle as a toggle write to the same bit. A design that let the write win would lose the event and read back 0.

It also writes ones while the enable bits are clear. A design that masked capture with the enable word would never record the bit, and one that ignored the toggle semantics would not clear it.

The bench writes to the status offset and to unmapped offsets, then reads every word back. A decoder that aliased those writes would disturb the interrupt words.

Random traffic mixes reads, writes and events against a bench model. This exposes an `irq` that is not delayed by exactly one cycle and read data that leaks a same-cycle write.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int unsigned STAT_OFFS = 32'h14;
  localparam int unsigned ISR_OFFS  = 32'h2C;
  localparam int unsigned IER_OFFS  = 32'h30;
  localparam int unsigned NUM_IRQ   = 2;   // index 1 = done, index 0 = error
endpackage

// File: rtl/dsi_rst_sync.sv
module dsi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dsi_irq_bank.sv
module dsi_irq_bank
  import dsi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               isr_wr,
  input  logic               ier_wr,
  input  logic [NUM_IRQ-1:0] wbits,
  input  logic [NUM_IRQ-1:0] evt,
  output logic [NUM_IRQ-1:0] isr_q,
  output logic [NUM_IRQ-1:0] ier_q,
  output logic               irq_q
);
  logic [NUM_IRQ-1:0] isr_d;
  logic [NUM_IRQ-1:0] ier_d;
  logic               irq_d;

  always_comb begin
    isr_d = isr_q;
    if (isr_wr) isr_d = isr_q ^ wbits;
    isr_d = isr_d | evt;              // a same-cycle event overrides the toggle
    ier_d = ier_q;
    if (ier_wr) ier_d = wbits;
    irq_d = |(isr_q & ier_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      ier_q <= '0;
      irq_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      ier_q <= ier_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/dsi_rd_mux.sv
module dsi_rd_mux
  import dsi_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               busy,
  input  logic               bus_err,
  input  logic [NUM_IRQ-1:0] isr,
  input  logic [NUM_IRQ-1:0] ier,
  output logic [DATA_W-1:0]  rdata_q
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFFS);
  localparam logic [ADDR_W-1:0] A_ISR  = ADDR_W'(ISR_OFFS);
  localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(IER_OFFS);
  localparam int unsigned       LOW_W  = DATA_W - NUM_IRQ;

  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    unique case (addr)
      A_STAT:  sel_word = {{(DATA_W-2){1'b0}}, bus_err, busy};
      A_ISR:   sel_word = {isr, {LOW_W{1'b0}}};
      A_IER:   sel_word = {ier, {LOW_W{1'b0}}};
      default: sel_word = '0;
    endcase
    rdata_d = rd_en ? sel_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
endmodule

// File: rtl/dma_stat_irq_regs.sv
module dma_stat_irq_regs
  import dsi_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_bus_err,
  input  logic              evt_done,
  input  logic              evt_err,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(ISR_OFFS);
  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(IER_OFFS);
  localparam int unsigned       LOW_W = DATA_W - NUM_IRQ;

  logic               rst_q_n;
  logic               isr_wr;
  logic               ier_wr;
  logic [NUM_IRQ-1:0] isr_q;
  logic [NUM_IRQ-1:0] ier_q;
  logic               unused_wdata;

  assign isr_wr       = reg_wr && (reg_addr == A_ISR);
  assign ier_wr       = reg_wr && (reg_addr == A_IER);
  assign unused_wdata = ^reg_wdata[LOW_W-1:0];

  dsi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  dsi_irq_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .isr_wr (isr_wr),
    .ier_wr (ier_wr),
    .wbits  (reg_wdata[DATA_W-1:LOW_W]),
    .evt    ({evt_done, evt_err}),
    .isr_q  (isr_q),
    .ier_q  (ier_q),
    .irq_q  (irq)
  );

  dsi_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .rd_en   (reg_rd),
    .addr    (reg_addr),
    .busy    (eng_busy),
    .bus_err (eng_bus_err),
    .isr     (isr_q),
    .ier     (ier_q),
    .rdata_q (reg_rdata)
  );
endmodule

module dma_stat_irq_regs_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              evt_done,
  input logic              evt_err,
  input logic [1:0]        isr,
  input logic [1:0]        ier,
  input logic              irq
);
  logic isr_wr_c;
  logic mapped_c;
  assign isr_wr_c = reg_wr && (reg_addr == ADDR_W'(32'h2C));
  assign mapped_c = (reg_addr == ADDR_W'(32'h14)) || (reg_addr == ADDR_W'(32'h2C)) ||
                    (reg_addr == ADDR_W'(32'h30));

  // R3
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n) evt_done |=> isr[1]);
  // R3
  err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n) evt_err |=> isr[0]);
  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_done && !isr_wr_c) |=> $stable(isr[1]));
  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr & ier)) |=> irq);
  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(isr & ier)) |=> !irq);
  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !mapped_c) |=> (reg_rdata == '0));
  // R1
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(32'h14)) |=> (reg_rdata[DATA_W-1:2] == '0));
endmodule

bind dma_stat_irq_regs dma_stat_irq_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .evt_done  (evt_done),
  .evt_err   (evt_err),
  .isr       (isr_q),
  .ier       (ier_q),
  .irq       (irq)
);

// File: tb/dma_stat_irq_regs_tb.sv
module dma_stat_irq_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_rd, reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              eng_busy, eng_bus_err, evt_done, evt_err;
  logic              irq;

  int checks = 0;
  int errors = 0;
  logic [1:0] isr_m, ier_m;
  logic       irq_m;
  bit         done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_stat_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .eng_bus_err(eng_bus_err), .evt_done(evt_done), .evt_err(evt_err), .irq(irq));

  function automatic logic [DATA_W-1:0] exp_word(input logic [ADDR_W-1:0] a,
      input logic b, input logic be, input logic [1:0] s, input logic [1:0] e);
    case (a)
      8'h14:   return {30'd0, be, b};
      8'h2C:   return {s, 30'd0};
      8'h30:   return {e, 30'd0};
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [ADDR_W-1:0] a);
    case (a)
      8'h14:   return "R1";
      8'h2C:   return "R3";
      8'h30:   return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic cyc(input logic rd, input logic wr, input logic [ADDR_W-1:0] a,
      input logic [DATA_W-1:0] wd, input logic dn, input logic er,
      input logic b, input logic be, input string rtag);
    logic [DATA_W-1:0] exp_rd;
    logic [1:0] tog;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    evt_done = dn; evt_err = er; eng_busy = b; eng_bus_err = be;
    exp_rd = exp_word(a, b, be, isr_m, ier_m);  // R9: value before same-cycle write
    tog = wd[31:30];
    @(posedge clk);
    irq_m = |(isr_m & ier_m);
    if (wr && a == 8'h2C) isr_m = isr_m ^ tog;
    isr_m = isr_m | {dn, er};
    if (wr && a == 8'h30) ier_m = tog;
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; evt_done = 0; evt_err = 0;
    if (rd) check(rtag, reg_rdata, exp_rd);
    check("R7", {31'd0, irq}, {31'd0, irq_m});
  endtask

  task automatic idle();
    cyc(0, 0, 8'h00, '0, 0, 0, eng_busy, eng_bus_err, "");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 0; reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    eng_busy = 0; eng_bus_err = 0; evt_done = 0; evt_err = 0;
    isr_m = 0; ier_m = 0; irq_m = 0;
    repeat (3) @(negedge clk);
    // R10: outputs zero during reset
    check("R10", reg_rdata, '0);
    check("R10", {31'd0, irq}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 reset state of both words
    cyc(1, 0, 8'h2C, '0, 0, 0, 0, 0, "R10");
    cyc(1, 0, 8'h30, '0, 0, 0, 0, 0, "R10");

    // R1 live status levels
    cyc(1, 0, 8'h14, '0, 0, 0, 1, 0, "R1");
    cyc(1, 0, 8'h14, '0, 0, 0, 0, 1, "R1");
    cyc(1, 0, 8'h14, '0, 0, 0, 1, 1, "R1");
    // R2 writes to status ignored
    cyc(0, 1, 8'h14, 32'hFFFF_FFFF, 0, 0, 0, 0, "");
    cyc(1, 0, 8'h14, '0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 8'h2C, '0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 8'h30, '0, 0, 0, 0, 0, "R2");

    // R3 capture with enables clear, no irq
    cyc(0, 0, 8'h00, '0, 1, 0, 0, 0, "");
    cyc(1, 0, 8'h2C, '0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 8'h00, '0, 0, 1, 0, 0, "");
    cyc(1, 0, 8'h2C, '0, 0, 0, 0, 0, "R3");
    // R4 toggle only the done bit, then error bit
    cyc(0, 1, 8'h2C, 32'h8000_0000, 0, 0, 0, 0, "");
    cyc(1, 0, 8'h2C, '0, 0, 0, 0, 0, "R4");
    cyc(0, 1, 8'h2C, 32'h4000_0000, 0, 0, 0, 0, "");
    cyc(1, 0, 8'h2C, '0, 0, 0, 0, 0, "R4");
    // R4 write of zero leaves bits
    cyc(0, 0, 8'h00, '0, 1, 1, 0, 0, "");
    cyc(0, 1, 8'h2C, 32'h3FFF_FFFF, 0, 0, 0, 0, "");
    cyc(1, 0, 8'h2C, '0, 0, 0, 0, 0, "R4");
    // R5 event and clearing write in the same cycle
    cyc(0, 1, 8'h2C, 32'hC000_0000, 1, 1, 0, 0, "");
    cyc(1, 0, 8'h2C, '0, 0, 0, 0, 0, "R5");
    // R6 enable word, other bits read 0
    cyc(0, 1, 8'h30, 32'hFFFF_FFFF, 0, 0, 0, 0, "");
    cyc(1, 0, 8'h30, '0, 0, 0, 0, 0, "R6");
    // R7 irq follows enabled status
    idle();
    cyc(0, 1, 8'h30, 32'h4000_0000, 0, 0, 0, 0, "");
    idle();
    cyc(0, 1, 8'h2C, 32'hC000_0000, 0, 0, 0, 0, "");
    idle();
    // R8 unmapped write and read
    cyc(0, 1, 8'h2D, 32'hFFFF_FFFF, 0, 0, 0, 0, "");
    cyc(0, 1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0, 0, "");
    cyc(1, 0, 8'h2D, '0, 0, 0, 1, 1, "R8");
    cyc(1, 0, 8'h30, '0, 0, 0, 0, 0, "R8");
    // R9 read and write in the same cycle returns the old value
    cyc(1, 1, 8'h30, 32'h8000_0000, 0, 0, 0, 0, "R9");
    cyc(1, 0, 8'h30, '0, 0, 0, 0, 0, "R9");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] a;
      int unsigned r;
      r = $urandom % 8;
      case (r)
        0, 1: a = 8'h14;
        2, 3, 4: a = 8'h2C;
        5, 6: a = 8'h30;
        default: a = 8'($urandom);
      endcase
      cyc(($urandom % 2) == 1, ($urandom % 3) == 0, a, $urandom,
          ($urandom % 6) == 0, ($urandom % 6) == 0,
          ($urandom % 2) == 1, ($urandom % 4) == 0, tag_of(a));
    end
    idle();

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule